// File: doc/BRIEF.md
# Mailbox Feature-Status Query Engine

This block runs a feature-status query on behalf of local logic, through a memory-mapped mailbox. Local logic gives a feature identifier and a single-cycle start. The engine then works through the mailbox on a 64-bit master port that carries one access at a time. That port reaches two words of the mailbox: a control/status word at the base address and a command/data word eight bytes above it.

The query starts with a claim handshake. The engine polls control until the mailbox has no owner and then writes the command. It polls again until the mailbox shows in-band ownership, and then starts the run by writing the run-busy flag with a packet length. The engine waits for run-busy to drop and checks the returned status code. If the code is good, it reads the command word back and decodes the enable and lock flags from the upper half. Whenever ownership was taken, the engine releases the mailbox by writing the completion flag, whether the run succeeded or failed.

Each poll loop samples at a fixed interval and gives up after a maximum wait. Both values are parameters counted in clock cycles; the defaults give 10 ms polls within 1 s at 125 MHz. When the query ends, the engine raises a single-cycle done together with an error code and the two flags. These outputs hold their values until the next query ends.

Top module: `fsq_query_engine`

## Requirements
- R1: If `base_valid` is low when a start is accepted, done rises on the next cycle with error code 1 (fault), locked and disabled at 0, and no bus request is made.
- R2: A bus request holds its address, direction and write data until the cycle in which it is acknowledged. Control is at `base_addr`+0 and the command word is at `base_addr`+8. The command write carries opcode 0x10 in bits [7:0] and the feature identifier from bit 40 upward.
- R3: The engine reads control until the owner field in bits [5:4] is 0 and then writes the command word. It then reads control until the owner field is 1 and writes 0x20001, which is run-busy in bit 0 plus a packet length of 2 in bits [23:16].
- R4: Within one poll loop, successive control reads start at least INTERVAL cycles apart. A loop gives up on the first failed read made once MAX_WAIT cycles have passed since the loop began.
- R5: If either owner wait gives up, the query ends with error code 2 and writes nothing to control after the command.
- R6: After the run write, control is polled until bit 0 reads 0. If this wait gives up, the error code is 3.
- R7: When run-busy clears with bits [15:8] other than 0x40, the error code is 4 and the command word is not read back.
- R8: On success the error code is 0. Disabled is set when bit 32 of the command read-back is 0, and locked is set when bit 63 is 1. Every error code clears both flags.
- R9: Once ownership is reached, the last bus access of the query is a write of 0x40 (completion only) to control. This holds for success, for a run-busy timeout and for a status mismatch.
- R10: Busy rises the cycle after an accepted start and falls the cycle after done. A start that arrives while busy is ignored and does not change the latched identifier.
- R11: Done is high for exactly one cycle. Error code, locked and disabled change only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a query (accepted when not busy) |
| feature_id | input | FID_W | Feature to query |
| base_valid | input | 1 | Mailbox base address is configured |
| base_addr | input | ADDR_W | Mailbox base address |
| busy | output | 1 | Query in progress |
| done | output | 1 | One-cycle end-of-query pulse |
| err_code | output | 3 | 0 ok, 1 fault, 2 owner timeout, 3 run-busy timeout, 4 bad status |
| locked | output | 1 | Feature write interface locked |
| disabled | output | 1 | Feature disabled |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Access byte address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 64 | Read data, valid with ack |

## Verification
The assertions check several properties on every cycle: the request holds steady until ack, done lasts one cycle, results change only with done, a missing base leads straight to a fault with no bus traffic, and every completion-ending query was preceded by an acknowledged completion write. The rest needs a mailbox model that reacts to what the engine writes, so only the bench scenarios can show it. That covers the order of the two owner waits, the exact command and run words, the poll spacing and give-up, the status-code branch, the flag decoding from the read-back, and that a start arriving while busy is lost.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int WORD_W = 64;
    localparam int CTRL_OFS = 0;
    localparam int CMD_OFS = 8;
    localparam logic [7:0] OP_GET_STATE = 8'h10;
    localparam int FID_LSB = 40;
    localparam logic [7:0] STATUS_GOOD = 8'h40;
    localparam logic [WORD_W-1:0] RUN_WORD = 64'h0000_0000_0002_0001;
    localparam logic [WORD_W-1:0] CPL_WORD = 64'h0000_0000_0000_0040;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_FAULT   = 3'd1,
        ERR_OWN_TMO = 3'd2,
        ERR_RB_TMO  = 3'd3,
        ERR_STATUS  = 3'd4
    } err_e;

    typedef enum logic [1:0] {
        PK_FREE,
        PK_INBAND,
        PK_RUN
    } poll_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL_RD,
        S_POLL_WAIT,
        S_WR_CMD,
        S_WR_RB,
        S_RD_CMD,
        S_WR_CPL,
        S_FIN
    } state_e;

    typedef struct packed {
        err_e err;
        logic locked;
        logic disabled;
    } result_t;

    function automatic result_t mk_err(input err_e e);
        result_t r;
        r.err = e;
        r.locked = 1'b0;
        r.disabled = 1'b0;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] make_cmd(input logic [23:0] fid);
        logic [WORD_W-1:0] w;
        w = {56'd0, OP_GET_STATE};
        w[FID_LSB +: 24] = fid;
        return w;
    endfunction

    function automatic logic poll_met(input poll_e k, input logic [WORD_W-1:0] w);
        case (k)
            PK_FREE:   return w[5:4] == 2'd0;
            PK_INBAND: return w[5:4] == 2'd1;
            default:   return !w[0];
        endcase
    endfunction

    function automatic logic status_ok(input logic [WORD_W-1:0] w);
        return w[15:8] == STATUS_GOOD;
    endfunction

    function automatic result_t decode(input logic [WORD_W-1:0] w);
        result_t r;
        r.err = ERR_NONE;
        r.locked = w[63];
        r.disabled = !w[32];
        return r;
    endfunction

endpackage

// File: rtl/fsq_poll_timer.sv
module fsq_poll_timer #(
    parameter int INTERVAL = 1_250_000,
    parameter int MAX_WAIT = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic ivl_load,
    output logic ivl_done,
    output logic expired
);
    localparam int EL_W = $clog2(MAX_WAIT + 2);
    localparam int IV_W = (INTERVAL > 1) ? $clog2(INTERVAL + 1) : 1;

    logic [EL_W-1:0] elapsed;
    logic [IV_W-1:0] ivl_cnt;

    assign expired = elapsed >= EL_W'(MAX_WAIT);
    assign ivl_done = ivl_cnt == '0;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            elapsed <= '0;
        end else if (run && !expired) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_cnt <= '0;
        end else if (ivl_load) begin
            ivl_cnt <= IV_W'(INTERVAL - 1);
        end else if (!ivl_done) begin
            ivl_cnt <= ivl_cnt - 1'b1;
        end
    end

    // R4: once the wait budget is spent it stays spent until the loop restarts
    p_expire_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        expired && !clr |=> expired);

endmodule

// File: rtl/fsq_sequencer.sv
module fsq_sequencer
    import fsq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FID_W-1:0]  feature_id,
    input  logic              base_valid,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              tmr_expired,
    input  logic              ivl_done,
    output logic              tmr_clr,
    output logic              tmr_run,
    output logic              ivl_load,
    output logic              busy,
    output logic              done,
    output result_t           res,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata
);
    state_e            st;
    poll_e             kind;
    logic [FID_W-1:0]  fid_q;
    logic [ADDR_W-1:0] base_q;
    result_t           pend;
    result_t           res_q;

    assign busy = st != S_IDLE;
    assign done = st == S_FIN;
    assign res = res_q;

    assign tmr_clr  = (st == S_IDLE) || ((st == S_WR_CMD || st == S_WR_RB) && bus_ack);
    assign tmr_run  = (st == S_POLL_RD) || (st == S_POLL_WAIT);
    assign ivl_load = (st == S_POLL_RD) && bus_ack;

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = base_q + ADDR_W'(CTRL_OFS);
        bus_wdata = '0;
        case (st)
            S_POLL_RD: bus_req = 1'b1;
            S_WR_CMD: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = base_q + ADDR_W'(CMD_OFS);
                bus_wdata = make_cmd(24'(fid_q));
            end
            S_WR_RB: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = RUN_WORD;
            end
            S_RD_CMD: begin
                bus_req  = 1'b1;
                bus_addr = base_q + ADDR_W'(CMD_OFS);
            end
            S_WR_CPL: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = CPL_WORD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            kind   <= PK_FREE;
            fid_q  <= '0;
            base_q <= '0;
            pend   <= mk_err(ERR_NONE);
            res_q  <= mk_err(ERR_NONE);
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    fid_q  <= feature_id;
                    base_q <= base_addr;
                    kind   <= PK_FREE;
                    if (!base_valid) begin
                        res_q <= mk_err(ERR_FAULT);
                        st    <= S_FIN;
                    end else begin
                        st <= S_POLL_RD;
                    end
                end
                S_POLL_RD: if (bus_ack) begin
                    if (poll_met(kind, bus_rdata)) begin
                        case (kind)
                            PK_FREE:   st <= S_WR_CMD;
                            PK_INBAND: st <= S_WR_RB;
                            default: begin
                                if (status_ok(bus_rdata)) begin
                                    st <= S_RD_CMD;
                                end else begin
                                    pend <= mk_err(ERR_STATUS);
                                    st   <= S_WR_CPL;
                                end
                            end
                        endcase
                    end else if (tmr_expired) begin
                        if (kind == PK_RUN) begin
                            pend <= mk_err(ERR_RB_TMO);
                            st   <= S_WR_CPL;
                        end else begin
                            res_q <= mk_err(ERR_OWN_TMO);
                            st    <= S_FIN;
                        end
                    end else begin
                        st <= S_POLL_WAIT;
                    end
                end
                S_POLL_WAIT: if (ivl_done) st <= S_POLL_RD;
                S_WR_CMD: if (bus_ack) begin
                    kind <= PK_INBAND;
                    st   <= S_POLL_RD;
                end
                S_WR_RB: if (bus_ack) begin
                    kind <= PK_RUN;
                    st   <= S_POLL_RD;
                end
                S_RD_CMD: if (bus_ack) begin
                    pend <= decode(bus_rdata);
                    st   <= S_WR_CPL;
                end
                S_WR_CPL: if (bus_ack) begin
                    res_q <= pend;
                    st    <= S_FIN;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    p_fault_nobus_r1: assert property (@(posedge clk) disable iff (rst)
        !busy && start && !base_valid |=> done && !bus_req && res_q.err == ERR_FAULT);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(res_q));

    p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> busy);

    p_owner_tmo_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        done && res_q.err == ERR_OWN_TMO |-> !$past(bus_we));

    p_cpl_last_r9: assert property (@(posedge clk) disable iff (rst)
        done && (res_q.err == ERR_NONE || res_q.err == ERR_RB_TMO || res_q.err == ERR_STATUS)
        |-> $past(bus_req && bus_ack && bus_we && bus_wdata == CPL_WORD));

endmodule

// File: rtl/fsq_query_engine.sv
module fsq_query_engine
    import fsq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FID_W = 8,
    parameter int INTERVAL = 1_250_000,
    parameter int MAX_WAIT = 125_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FID_W-1:0]  feature_id,
    input  logic              base_valid,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic              locked,
    output logic              disabled,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [63:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [63:0]       bus_rdata
);
    logic    tmr_clr, tmr_run, ivl_load, ivl_done, tmr_expired;
    result_t res;

    fsq_poll_timer #(
        .INTERVAL (INTERVAL),
        .MAX_WAIT (MAX_WAIT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .run      (tmr_run),
        .ivl_load (ivl_load),
        .ivl_done (ivl_done),
        .expired  (tmr_expired)
    );

    fsq_sequencer #(
        .ADDR_W (ADDR_W),
        .FID_W  (FID_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .feature_id  (feature_id),
        .base_valid  (base_valid),
        .base_addr   (base_addr),
        .tmr_expired (tmr_expired),
        .ivl_done    (ivl_done),
        .tmr_clr     (tmr_clr),
        .tmr_run     (tmr_run),
        .ivl_load    (ivl_load),
        .busy        (busy),
        .done        (done),
        .res         (res),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata)
    );

    assign err_code = res.err;
    assign locked   = res.locked;
    assign disabled = res.disabled;

endmodule

// File: tb/fsq_query_engine_bench.sv
module fsq_query_engine_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ADDR_W = 16;
    localparam int FID_W = 8;
    localparam int IVL = 3;
    localparam int MAXW = 30;
    localparam logic [ADDR_W-1:0] BASE = 16'h1200;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [FID_W-1:0]  feature_id = '0;
    logic              base_valid = 1'b0;
    logic              busy, done, locked, disabled;
    logic [2:0]        err_code;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [63:0]       bus_wdata;
    logic              bus_ack = 1'b0;
    logic [63:0]       bus_rdata = '0;

    always #4 clk = ~clk; // 125 MHz

    fsq_query_engine #(
        .ADDR_W (ADDR_W), .FID_W (FID_W), .INTERVAL (IVL), .MAX_WAIT (MAXW)
    ) u_fsq_query_engine (
        .clk (clk), .rst (rst), .start (start), .feature_id (feature_id),
        .base_valid (base_valid), .base_addr (BASE), .busy (busy), .done (done),
        .err_code (err_code), .locked (locked), .disabled (disabled),
        .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_ack (bus_ack), .bus_rdata (bus_rdata)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural mailbox: owner/run state advances with the engine's writes and read count
    int free_after = 0, inband_after = 0, run_after = 0;
    logic [7:0]  stat_code = 8'h40;
    logic [31:0] resp_word = '0;
    int phase = 0, rd_cnt = 0, cyc = 0, last_rd = -1, min_gap = 1000;
    int n_ctrl_rd = 0, n_cmd_rd = 0;
    logic [63:0]       wd_q[$];
    logic [ADDR_W-1:0] wa_q[$];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            bus_ack <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                wd_q.push_back(bus_wdata);
                wa_q.push_back(bus_addr);
                if (bus_addr == BASE + 16'd8) phase = 1;
                else if (bus_wdata[0]) phase = 2;
                else phase = 3;
                rd_cnt = 0;
                last_rd = -1;
                bus_rdata <= '0;
            end else if (bus_addr == BASE) begin
                logic [63:0] v;
                n_ctrl_rd++;
                if (last_rd >= 0 && cyc - last_rd < min_gap) min_gap = cyc - last_rd;
                last_rd = cyc;
                v = '0;
                if (phase == 0) v[5:4] = (rd_cnt >= free_after) ? 2'd0 : 2'd2;
                else if (phase == 1) v[5:4] = (rd_cnt >= inband_after) ? 2'd1 : 2'd0;
                else begin
                    v[5:4] = 2'd1;
                    v[0] = rd_cnt < run_after;
                    v[15:8] = stat_code;
                end
                rd_cnt++;
                bus_rdata <= v;
            end else begin
                n_cmd_rd++;
                bus_rdata <= {resp_word, 32'h0};
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    // Per-clock model: done is a one-cycle pulse and results move only with it (R11)
    bit prev_done = 0, seen_done = 0;
    logic [4:0] held;
    int done_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) chk(0, "R11 done lasted two cycles", 1, 0);
            if (!done && seen_done)
                chk({err_code, locked, disabled} == held, "R11 result hold", {err_code, locked, disabled}, held);
            if (done) begin
                held = {err_code, locked, disabled};
                seen_done = 1;
                done_cnt++;
            end
            prev_done = done;
        end
    end

    task automatic run_q(input logic [7:0] fid, input bit bv, input bit inject,
                         input int e_err, input bit e_l, input bit e_d,
                         input int e_nwr, input bit e_cpl, input string tg);
        int lat;
        int d0;
        logic [63:0] cmd;
        wd_q.delete();
        wa_q.delete();
        n_ctrl_rd = 0; n_cmd_rd = 0; min_gap = 1000; phase = 0; rd_cnt = 0; last_rd = -1;
        cmd = 64'h10 | (64'(fid) << 40);
        @(negedge clk);
        chk(!busy, {tg, " R10 idle before start"}, busy, 0);
        d0 = done_cnt;
        start = 1'b1; feature_id = fid; base_valid = bv;
        @(negedge clk);
        start = 1'b0;
        chk(busy, {tg, " R10 busy after start"}, busy, 1);
        if (inject) begin
            @(negedge clk);
            @(negedge clk);
            start = 1'b1; feature_id = 8'hEE;
            @(negedge clk);
            start = 1'b0;
        end
        lat = 0;
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
        chk(done, {tg, " query finished"}, done, 1);
        chk(err_code == 3'(e_err), {tg, " error code"}, err_code, e_err);
        chk(locked == e_l, {tg, " R8 locked"}, locked, e_l);
        chk(disabled == e_d, {tg, " R8 disabled"}, disabled, e_d);
        if (!bv) chk(lat == 0 && n_ctrl_rd == 0 && n_cmd_rd == 0, {tg, " R1 fault immediate, no bus"}, lat, 0);
        @(negedge clk);
        chk(!done && !busy, {tg, " R11/R10 done pulse ends and busy drops"}, {done, busy}, 0);
        chk(done_cnt - d0 == 1, {tg, " R10 exactly one completion"}, done_cnt - d0, 1);
        chk(wd_q.size() == e_nwr, {tg, " write count"}, wd_q.size(), e_nwr);
        chk(n_cmd_rd == ((e_err == 0) ? 1 : 0), {tg, " R7 command read-back only on good status"}, n_cmd_rd, (e_err == 0));
        if (wd_q.size() >= 1 && e_nwr >= 1)
            chk(wd_q[0] == cmd && wa_q[0] == BASE + 16'd8, {tg, " R2 command word/address"}, wd_q[0], cmd);
        if (wd_q.size() >= 2 && e_nwr >= 2)
            chk(wd_q[1] == 64'h20001 && wa_q[1] == BASE, {tg, " R3 run word"}, wd_q[1], 64'h20001);
        if (e_cpl && wd_q.size() > 0)
            chk(wd_q[$] == 64'h40 && wa_q[$] == BASE, {tg, " R9 completion written last"}, wd_q[$], 64'h40);
        if (!e_cpl)
            foreach (wd_q[i]) chk(wd_q[i] != 64'h40, {tg, " R5 no completion write"}, wd_q[i], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req, "reset R10 idle outputs", {busy, done, bus_req}, 0);
        chk(err_code == 3'd0 && !locked && !disabled, "reset R11 result cleared", err_code, 0);
        rst = 1'b0;

        // R1: no base configured
        run_q(8'h21, 1'b0, 1'b0, 1, 0, 0, 0, 0, "fault");

        // R3 R4 R8 R9: success, enabled and unlocked, with two owner polls
        free_after = 2; inband_after = 1; run_after = 2; stat_code = 8'h40; resp_word = 32'h0000_0001;
        run_q(8'h05, 1'b1, 1'b0, 0, 0, 0, 3, 1, "ok_plain");
        chk(min_gap >= IVL, "R4 poll spacing", min_gap, IVL);

        // R8: disabled and locked
        free_after = 0; inband_after = 0; run_after = 0; resp_word = 32'h8000_0000;
        run_q(8'hA3, 1'b1, 1'b0, 0, 1, 1, 3, 1, "ok_locked");

        // R7 R9: status mismatch
        stat_code = 8'h41; run_after = 1;
        run_q(8'h11, 1'b1, 1'b0, 4, 0, 0, 3, 1, "bad_status");
        stat_code = 8'h40;

        // R5 R4: never free
        free_after = 1000;
        run_q(8'h12, 1'b1, 1'b0, 2, 0, 0, 0, 0, "own0_tmo");
        chk(n_ctrl_rd >= 2, "R4 repeated polls before giving up", n_ctrl_rd, 2);
        free_after = 0;

        // R5: never in-band
        inband_after = 1000;
        run_q(8'h13, 1'b1, 1'b0, 2, 0, 0, 1, 0, "own1_tmo");
        inband_after = 0;

        // R6 R9: run-busy never clears
        run_after = 1000;
        run_q(8'h14, 1'b1, 1'b0, 3, 0, 0, 3, 1, "rb_tmo");
        run_after = 0;

        // R10: start while busy is ignored
        free_after = 3; resp_word = 32'h8000_0001;
        run_q(8'h3C, 1'b1, 1'b1, 0, 1, 0, 3, 1, "busy_ignore");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule